// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Sequencer

This block runs single accesses to external asynchronous SRAM, PSRAM or NOR parts over a shared parallel bus. Each device has its own active-low chip select. Address, data, output enable, write enable and the byte-lane strobes are common to all devices. A simple valid/ready request port takes one access at a time. Reads return data on a one-cycle response strobe.

Every access walks through the same phases, and each phase is skipped when its programmed cycle count is zero:

1. Optional byte-lane setup.
2. Address setup.
3. Address hold, used only when address and data share the data pins.
4. Data phase, which always lasts at least one cycle.
5. Data hold.
6. Bus turnaround.

Reads and writes take their phase counts from separate configuration inputs. Only the byte-lane setup count is shared. The bus can be 8 or 16 bits wide.

An external wait input can stretch the data phase. It is honoured only when enabled, and its active level is selectable.

Top module: `asram_seq`

## Requirements
- R1: `req_ready` is high only when no access is in progress. During an access, exactly the `mem_ce_n` bit chosen by `req_sel` is low. All chip selects are high otherwise.
- R2: For a read, the chip select stays low for `rd_aset + ahold + max(rd_dset,1) + rd_dhld` cycles. `ahold` is `rd_ahld` in multiplexed mode and 0 otherwise.
- R3: `mem_adv_n` is low for exactly the address-setup count, at the start of the chip-select window. `mem_addr` carries the request address throughout the window. Both strobes stay high while `mem_adv_n` is low.
- R4: `mem_oe_n` (read) or `mem_we_n` (write) is low for `max(data-setup,1)` cycles, and the two are never low together. A zero count removes every other phase entirely.
- R5: Writes take every phase length from the `cfg_wr_*` inputs instead of `cfg_rd_*`.
- R6: After the strobe rises, the chip select stays low for the data-hold count. During data hold on a write, `mem_dq_o` keeps the write data with `mem_dq_oe` high.
- R7: After the chip select rises, `req_ready` stays low for the turnaround count, and then returns high.
- R8: `mem_bl_n` equals the inverted byte enables for the whole access. It falls `cfg_bl_setup` cycles before the chip select falls.
- R9: Multiplexing applies when `cfg_mux` is 1 and `cfg_kind` is not 0.
  - Kind codes: 0 is SRAM/FRAM, 1 is PSRAM, 2 and 3 are NOR.
  - Address setup: `mem_dq_o` holds the low address bits with `mem_dq_oe` high.
  - Address hold: the data bus keeps the address while `mem_adv_n` is high.
  - Read data phase: the data bus is released.
- R10: With `cfg_bus16` = 0 (8-bit bus), `mem_dq_o[15:8]` is 0, `mem_bl_n[1]` stays 1 and `rsp_rdata[15:8]` is 0.
- R11: Wait is active when `cfg_wait_en` is 1 and `mem_wait` equals `cfg_wait_high`. Each wait-active cycle in the data phase lengthens that phase by one cycle. With `cfg_wait_en` = 0, `mem_wait` has no effect.
- R12: A read raises `rsp_valid` for one cycle, in the cycle right after the data phase ends. `rsp_rdata` then holds `mem_dq_i` as sampled in the last data-phase cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | SW | Device (chip select) index |
| req_addr | input | AW | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_kind | input | 2 | Device kind: 0 SRAM/FRAM, 1 PSRAM, 2/3 NOR |
| cfg_mux | input | 1 | Address/data multiplexing request |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait_en | input | 1 | Honour wait input |
| cfg_wait_high | input | 1 | Wait active level |
| cfg_bl_setup | input | CW | Byte-lane setup cycles |
| cfg_rd_aset | input | CW | Read address-setup cycles |
| cfg_rd_ahld | input | CW | Read address-hold cycles |
| cfg_rd_dset | input | CW | Read data-phase cycles |
| cfg_rd_dhld | input | CW | Read data-hold cycles |
| cfg_rd_turn | input | CW | Read turnaround cycles |
| cfg_wr_aset | input | CW | Write address-setup cycles |
| cfg_wr_ahld | input | CW | Write address-hold cycles |
| cfg_wr_dset | input | CW | Write data-phase cycles |
| cfg_wr_dhld | input | CW | Write data-hold cycles |
| cfg_wr_turn | input | CW | Write turnaround cycles |
| mem_ce_n | output | NCS | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane strobes, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_dq_o | output | 16 | Data bus out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus in |
| mem_wait | input | 1 | External wait |

## Verification
The bench follows the bus outputs cycle by cycle on the falling clock edge.

**Phase lengths.** For each access it counts the cycles spent in each visible phase:
- byte lanes low before the chip select;
- `mem_adv_n` low;
- chip select low;
- strobe low;
- chip select high with `req_ready` still low.

When `req_ready` returns, these counts are compared with lengths worked out in advance from the configuration, including any enabled wait cycles.

**Read responses.** Each read pushes its expected data, and that data must appear on `rsp_valid`. `rsp_valid` must come exactly one cycle after the last sampled `mem_oe_n` low.

**Wait stimulus.** Wait is raised at the falling edge that first shows the strobe low. Each wait cycle therefore holds exactly one rising edge.

// File: rtl/asram_seq.sv
module asram_seq #(
  parameter int AW  = 24,
  parameter int NCS = 2,
  parameter int CW  = 4,
  parameter int SW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [SW-1:0]  req_sel,
  input  logic [AW-1:0]  req_addr,
  input  logic [15:0]    req_wdata,
  input  logic [1:0]     req_be,
  output logic           rsp_valid,
  output logic [15:0]    rsp_rdata,
  input  logic [1:0]     cfg_kind,
  input  logic           cfg_mux,
  input  logic           cfg_bus16,
  input  logic           cfg_wait_en,
  input  logic           cfg_wait_high,
  input  logic [CW-1:0]  cfg_bl_setup,
  input  logic [CW-1:0]  cfg_rd_aset,
  input  logic [CW-1:0]  cfg_rd_ahld,
  input  logic [CW-1:0]  cfg_rd_dset,
  input  logic [CW-1:0]  cfg_rd_dhld,
  input  logic [CW-1:0]  cfg_rd_turn,
  input  logic [CW-1:0]  cfg_wr_aset,
  input  logic [CW-1:0]  cfg_wr_ahld,
  input  logic [CW-1:0]  cfg_wr_dset,
  input  logic [CW-1:0]  cfg_wr_dhld,
  input  logic [CW-1:0]  cfg_wr_turn,
  output logic [NCS-1:0] mem_ce_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic [1:0]     mem_bl_n,
  output logic           mem_adv_n,
  output logic [AW-1:0]  mem_addr,
  output logic [15:0]    mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [15:0]    mem_dq_i,
  input  logic           mem_wait
);

  localparam int DW = 16;
  localparam logic [1:0] KIND_SRAM = 2'd0;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_BLS, S_ASET, S_AHLD, S_DSET, S_DHLD, S_TURN
  } phase_e;

  phase_e          st, nxt_st;
  logic [CW-1:0]   cnt, nxt_cnt;
  logic            q_wr;
  logic [SW-1:0]   q_sel;
  logic [AW-1:0]   q_addr;
  logic [DW-1:0]   q_wdata;
  logic [1:0]      q_be;

  logic            wr_sel, mux_on, wait_act, last;
  logic [CW-1:0]   t_aset, t_ahld, t_dset, t_dhld, t_turn, t_ahld_eff, t_dset_eff;
  phase_e          tr_st, dh_st, ah_st, as_st, bl_st;
  logic [CW-1:0]   tr_cnt, dh_cnt, ah_cnt, as_cnt, bl_cnt;

  assign wr_sel     = (st == S_IDLE) ? req_write : q_wr;
  assign t_aset     = wr_sel ? cfg_wr_aset : cfg_rd_aset;
  assign t_ahld     = wr_sel ? cfg_wr_ahld : cfg_rd_ahld;
  assign t_dset     = wr_sel ? cfg_wr_dset : cfg_rd_dset;
  assign t_dhld     = wr_sel ? cfg_wr_dhld : cfg_rd_dhld;
  assign t_turn     = wr_sel ? cfg_wr_turn : cfg_rd_turn;
  assign mux_on     = cfg_mux && (cfg_kind != KIND_SRAM);
  assign t_ahld_eff = mux_on ? t_ahld : '0;
  assign t_dset_eff = (t_dset == '0) ? ONE : t_dset;
  assign wait_act   = cfg_wait_en && (mem_wait == cfg_wait_high);
  assign last       = (cnt == ONE);

  assign tr_st  = (t_turn != '0) ? S_TURN : S_IDLE;
  assign tr_cnt = t_turn;
  assign dh_st  = (t_dhld != '0) ? S_DHLD : tr_st;
  assign dh_cnt = (t_dhld != '0) ? t_dhld : tr_cnt;
  assign ah_st  = (t_ahld_eff != '0) ? S_AHLD : S_DSET;
  assign ah_cnt = (t_ahld_eff != '0) ? t_ahld_eff : t_dset_eff;
  assign as_st  = (t_aset != '0) ? S_ASET : ah_st;
  assign as_cnt = (t_aset != '0) ? t_aset : ah_cnt;
  assign bl_st  = (cfg_bl_setup != '0) ? S_BLS : as_st;
  assign bl_cnt = (cfg_bl_setup != '0) ? cfg_bl_setup : as_cnt;

  always_comb begin
    nxt_st  = st;
    nxt_cnt = cnt;
    unique case (st)
      S_IDLE: if (req_valid) begin nxt_st = bl_st; nxt_cnt = bl_cnt; end
      S_BLS:  if (last) begin nxt_st = as_st; nxt_cnt = as_cnt; end
              else nxt_cnt = cnt - ONE;
      S_ASET: if (last) begin nxt_st = ah_st; nxt_cnt = ah_cnt; end
              else nxt_cnt = cnt - ONE;
      S_AHLD: if (last) begin nxt_st = S_DSET; nxt_cnt = t_dset_eff; end
              else nxt_cnt = cnt - ONE;
      S_DSET: if (!wait_act) begin
                if (last) begin nxt_st = dh_st; nxt_cnt = dh_cnt; end
                else nxt_cnt = cnt - ONE;
              end
      S_DHLD: if (last) begin nxt_st = tr_st; nxt_cnt = tr_cnt; end
              else nxt_cnt = cnt - ONE;
      S_TURN: if (last) begin nxt_st = S_IDLE; nxt_cnt = '0; end
              else nxt_cnt = cnt - ONE;
      default: begin nxt_st = S_IDLE; nxt_cnt = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      q_wr      <= 1'b0;
      q_sel     <= '0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_be      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st        <= nxt_st;
      cnt       <= nxt_cnt;
      rsp_valid <= (st == S_DSET) && !q_wr && !wait_act && last;
      if ((st == S_DSET) && !q_wr && !wait_act && last)
        rsp_rdata <= cfg_bus16 ? mem_dq_i : {8'h00, mem_dq_i[7:0]};
      if ((st == S_IDLE) && req_valid) begin
        q_wr    <= req_write;
        q_sel   <= req_sel;
        q_addr  <= req_addr;
        q_wdata <= req_wdata;
        q_be    <= req_be;
      end
    end
  end

  logic lanes_on, cs_on, addr_ph, data_ph;
  logic [DW-1:0] dq_raw;

  assign lanes_on  = (st != S_IDLE) && (st != S_TURN);
  assign cs_on     = lanes_on && (st != S_BLS);
  assign addr_ph   = (st == S_ASET) || (st == S_AHLD);
  assign data_ph   = (st == S_DSET) || (st == S_DHLD);

  assign req_ready = (st == S_IDLE);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign mem_ce_n[i] = !(cs_on && (q_sel == SW'(i)));
  end

  assign mem_bl_n  = lanes_on ? {~(q_be[1] & cfg_bus16), ~q_be[0]} : 2'b11;
  assign mem_oe_n  = !((st == S_DSET) && !q_wr);
  assign mem_we_n  = !((st == S_DSET) && q_wr);
  assign mem_adv_n = !(st == S_ASET);
  assign mem_addr  = q_addr;
  assign mem_dq_oe = (mux_on && addr_ph) || (q_wr && (data_ph || addr_ph));
  assign dq_raw    = (mux_on && addr_ph) ? DW'(q_addr) : q_wdata;
  assign mem_dq_o  = cfg_bus16 ? dq_raw : {8'h00, dq_raw[7:0]};

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic [NCS-1:0] mem_ce_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_adv_n,
  input logic [1:0]     mem_bl_n,
  input logic           mem_dq_oe,
  input logic           mem_wait,
  input logic           cfg_bus16,
  input logic           cfg_wait_en,
  input logic           cfg_wait_high
);

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n)); // R1
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_ce_n)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_ce_n)); // R4
  AST_ADV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_oe_n && mem_we_n && !(&mem_ce_n))); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R9
  AST_LANE8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bus16 |-> mem_bl_n[1]); // R10
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && cfg_wait_en && (mem_wait == cfg_wait_high)) |=> !mem_oe_n); // R11
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R12

endmodule

bind asram_seq asram_seq_chk #(.NCS(NCS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_adv_n(mem_adv_n), .mem_bl_n(mem_bl_n), .mem_dq_oe(mem_dq_oe),
  .mem_wait(mem_wait), .cfg_bus16(cfg_bus16), .cfg_wait_en(cfg_wait_en),
  .cfg_wait_high(cfg_wait_high)
);

// File: tb/asram_seq_tb_top.sv
`timescale 1ns/1ps
module asram_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_ready;
  logic [0:0]  req_sel = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  cfg_kind = 2'd1;
  logic        cfg_mux = 0, cfg_bus16 = 1, cfg_wait_en = 0, cfg_wait_high = 0;
  logic [3:0]  cfg_bl_setup = 0;
  logic [3:0]  rd_aset = 0, rd_ahld = 0, rd_dset = 0, rd_dhld = 0, rd_turn = 0;
  logic [3:0]  wr_aset = 0, wr_ahld = 0, wr_dset = 0, wr_dhld = 0, wr_turn = 0;
  logic [1:0]  mem_ce_n, mem_bl_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [23:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic        mem_wait = 1'b1;

  assign mem_dq_i = !mem_oe_n ? (mem_addr[15:0] ^ 16'h5A3C) : 16'hFFFF;

  asram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cfg_kind(cfg_kind), .cfg_mux(cfg_mux),
    .cfg_bus16(cfg_bus16), .cfg_wait_en(cfg_wait_en), .cfg_wait_high(cfg_wait_high),
    .cfg_bl_setup(cfg_bl_setup),
    .cfg_rd_aset(rd_aset), .cfg_rd_ahld(rd_ahld), .cfg_rd_dset(rd_dset),
    .cfg_rd_dhld(rd_dhld), .cfg_rd_turn(rd_turn),
    .cfg_wr_aset(wr_aset), .cfg_wr_ahld(wr_ahld), .cfg_wr_dset(wr_dset),
    .cfg_wr_dhld(wr_dhld), .cfg_wr_turn(wr_turn),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bl_n(mem_bl_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_wait(mem_wait)
  );

  typedef struct {
    string       tag;
    bit          wr;
    int          sel;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [15:0] ad;
    logic [1:0]  bl;
    bit          mux;
    bit          b16;
    int          n_bls, n_adv, n_ce, n_oe, n_we, n_turn;
  } exp_t;

  exp_t        exq[$];
  logic [15:0] rdq[$];
  int n_chk = 0, n_bad = 0, done_cnt = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: per-access phase counting and response scoreboard
  bit busy = 0, seen_ce = 0, seen_we = 0, prev_oe = 0;
  bit ok_cs, ok_bus, ok_bl, ok_hold;
  int m_bls, m_adv, m_ce, m_oe, m_we, m_turn;
  always @(negedge clk) begin : mon
    exp_t cur;
    logic [15:0] rexp;
    if (rst_n) begin
      if (rsp_valid) begin
        if (rdq.size() == 0) check(0, "R12 response without read", int'(rsp_rdata), 0);
        else begin
          rexp = rdq.pop_front();
          check(rsp_rdata == rexp, "R12 read data", int'(rsp_rdata), int'(rexp));
          check(prev_oe, "R12 response one cycle after data phase", 0, 1);
        end
      end
      prev_oe = !mem_oe_n;
      if (!busy && !req_ready) begin
        busy = 1; seen_ce = 0; seen_we = 0;
        ok_cs = 1; ok_bus = 1; ok_bl = 1; ok_hold = 1;
        m_bls = 0; m_adv = 0; m_ce = 0; m_oe = 0; m_we = 0; m_turn = 0;
      end
      if (busy && exq.size() > 0) begin
        cur = exq[0];
        if (mem_bl_n != 2'b11 && mem_bl_n != cur.bl) ok_bl = 0;
        if (!cur.b16 && mem_dq_o[15:8] != 8'h00) ok_bus = 0;
        if (mem_ce_n != 2'b11) begin
          seen_ce = 1;
          m_ce++;
          if (mem_ce_n != ~(2'b01 << cur.sel)) ok_cs = 0;
          if (mem_bl_n != cur.bl) ok_bl = 0;
          if (mem_addr != cur.addr) ok_bus = 0;
          if (!mem_adv_n) begin
            m_adv++;
            if (cur.mux && !(mem_dq_oe && mem_dq_o == cur.ad)) ok_bus = 0;
            if (!cur.mux && !cur.wr && mem_dq_oe) ok_bus = 0;
          end
          if (!mem_oe_n) begin
            m_oe++;
            if (mem_dq_oe) ok_bus = 0;
          end
          if (!mem_we_n) begin
            m_we++; seen_we = 1;
            if (!(mem_dq_oe && mem_dq_o == cur.wd)) ok_bus = 0;
          end else if (cur.wr && seen_we) begin
            if (!(mem_dq_oe && mem_dq_o == cur.wd)) ok_hold = 0;
          end
        end else if (!seen_ce && mem_bl_n != 2'b11) m_bls++;
        else if (seen_ce && !req_ready) m_turn++;
        if (req_ready) begin
          check(ok_cs, {cur.tag, " R1 chip select choice"}, 0, 1);
          check(m_ce == cur.n_ce, {cur.tag, " R2 chip-select cycles"}, m_ce, cur.n_ce);
          check(m_adv == cur.n_adv, {cur.tag, " R3 address-valid cycles"}, m_adv, cur.n_adv);
          check(m_oe == cur.n_oe, {cur.tag, " R4 output-enable cycles"}, m_oe, cur.n_oe);
          check(m_we == cur.n_we, {cur.tag, " R4 write-enable cycles"}, m_we, cur.n_we);
          check(ok_hold, {cur.tag, " R6 write data held"}, 0, 1);
          check(m_turn == cur.n_turn, {cur.tag, " R7 turnaround cycles"}, m_turn, cur.n_turn);
          check(m_bls == cur.n_bls, {cur.tag, " R8 byte-lane lead cycles"}, m_bls, cur.n_bls);
          check(ok_bl, {cur.tag, " R8 byte-lane value"}, int'(mem_bl_n), int'(cur.bl));
          check(ok_bus, {cur.tag, " R9 data bus contents"}, 0, 1);
          void'(exq.pop_front());
          busy = 0;
          done_cnt++;
        end
      end
    end
  end

  // Driver: computes expectations, pushes them, issues the request
  task automatic access(input string tag, input bit wr, input int sel,
                        input logic [23:0] addr, input logic [15:0] wd,
                        input logic [1:0] be, input int wcyc);
    exp_t e;
    int ds, ah, w, target;
    logic [15:0] m;
    m = cfg_bus16 ? 16'hFFFF : 16'h00FF;
    e.tag = tag; e.wr = wr; e.sel = sel; e.addr = addr;
    e.wd = wd & m; e.ad = addr[15:0] & m;
    e.bl = cfg_bus16 ? ~be : {1'b1, ~be[0]};
    e.mux = cfg_mux && (cfg_kind != 2'd0);
    e.b16 = cfg_bus16;
    ds = wr ? int'(wr_dset) : int'(rd_dset);
    if (ds == 0) ds = 1;
    ah = e.mux ? (wr ? int'(wr_ahld) : int'(rd_ahld)) : 0;
    w  = cfg_wait_en ? wcyc : 0;
    e.n_bls  = int'(cfg_bl_setup);
    e.n_adv  = wr ? int'(wr_aset) : int'(rd_aset);
    e.n_ce   = e.n_adv + ah + ds + w + (wr ? int'(wr_dhld) : int'(rd_dhld));
    e.n_oe   = wr ? 0 : ds + w;
    e.n_we   = wr ? ds + w : 0;
    e.n_turn = wr ? int'(wr_turn) : int'(rd_turn);
    exq.push_back(e);
    if (!wr) rdq.push_back((addr[15:0] ^ 16'h5A3C) & m);
    target = done_cnt + 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_sel = 1'(sel);
    req_addr = addr; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 0;
    if (wcyc > 0) begin
      while (mem_oe_n && mem_we_n) @(negedge clk);
      mem_wait = cfg_wait_high;
      repeat (wcyc) @(negedge clk);
      mem_wait = !cfg_wait_high;
    end
    wait (done_cnt == target);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(0, "R1 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 reset ready", int'(req_ready), 1);
    check(mem_ce_n == 2'b11, "R1 reset chip selects", int'(mem_ce_n), 3);
    check(mem_oe_n && mem_we_n && mem_adv_n, "R4 reset strobes", 0, 1);
    check(!rsp_valid && !mem_dq_oe, "R12 reset response", int'(rsp_valid), 0);

    // plain read, non-multiplexed: address hold ignored
    cfg_bl_setup = 1; rd_aset = 2; rd_ahld = 3; rd_dset = 3; rd_dhld = 1; rd_turn = 2;
    wr_aset = 1; wr_ahld = 2; wr_dset = 4; wr_dhld = 2; wr_turn = 3;
    access("R2", 0, 0, 24'h12_3456, 16'h0, 2'b11, 0);
    // write uses its own counts
    access("R5", 1, 0, 24'h00_0ABC, 16'hBEEF, 2'b01, 0);
    // all-zero counts: one strobe cycle only
    cfg_bl_setup = 0; rd_aset = 0; rd_ahld = 0; rd_dset = 0; rd_dhld = 0; rd_turn = 0;
    access("R4", 0, 1, 24'h00_1111, 16'h0, 2'b11, 0);
    wr_aset = 0; wr_dset = 0; wr_dhld = 0; wr_turn = 0;
    access("R4", 1, 1, 24'h00_2222, 16'h1234, 2'b10, 0);
    // multiplexed PSRAM read and NOR write
    cfg_mux = 1; cfg_kind = 2'd1; cfg_bl_setup = 2;
    rd_aset = 2; rd_ahld = 2; rd_dset = 2; rd_dhld = 1; rd_turn = 1;
    access("R9", 0, 0, 24'hAB_CDEF, 16'h0, 2'b11, 0);
    cfg_kind = 2'd2; wr_aset = 1; wr_ahld = 1; wr_dset = 3; wr_dhld = 1; wr_turn = 2;
    access("R9", 1, 1, 24'h01_7E55, 16'hC0DE, 2'b11, 0);
    // SRAM kind: multiplexing request has no effect
    cfg_kind = 2'd0;
    access("R9", 0, 0, 24'h03_0303, 16'h0, 2'b11, 0);
    // 8-bit bus
    cfg_mux = 0; cfg_bus16 = 0; cfg_kind = 2'd1;
    access("R10", 1, 0, 24'h00_4411, 16'hA5C7, 2'b11, 0);
    access("R10", 0, 1, 24'h00_77F0, 16'h0, 2'b11, 0);
    cfg_mux = 1;
    access("R10", 0, 0, 24'h00_9A9B, 16'h0, 2'b01, 0);
    // wait handling
    cfg_mux = 0; cfg_bus16 = 1; cfg_wait_en = 1; cfg_wait_high = 0; mem_wait = 1;
    access("R11", 0, 0, 24'h00_5151, 16'h0, 2'b11, 3);
    cfg_wait_high = 1; mem_wait = 0;
    access("R11", 1, 1, 24'h00_6262, 16'h7070, 2'b11, 2);
    cfg_wait_en = 0;
    access("R11", 0, 1, 24'h00_7373, 16'h0, 2'b11, 4);
    // back-to-back reads on both chip selects
    cfg_bl_setup = 0; rd_aset = 1; rd_dset = 1; rd_dhld = 0; rd_turn = 0;
    access("R1", 0, 1, 24'h00_0001, 16'h0, 2'b11, 0);
    access("R1", 0, 0, 24'h00_0002, 16'h0, 2'b11, 0);
    repeat (4) @(negedge clk);
    check(rdq.size() == 0, "R12 all read responses seen", rdq.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule